// File: doc/BRIEF.md
# Framed Byte-Stream Packet Receiver

This block turns a byte-wide link back into 104-bit mesh packets. Each capture edge of the link carries one byte and one frame bit, and the model here treats every edge as one clock cycle. A packet begins on the edge where the frame bit goes from low to high. The header byte of that packet sets its length: either 9 or 13 bytes. The receiver collects the header, the destination address, the data word and, when the packet has one, the source address. It writes the finished packet into a two-entry output buffer. Downstream logic takes packets from that buffer with a valid/ready handshake.

A sender that keeps the frame bit high after the last byte of a packet starts streaming. The next byte on the link is then the first data byte of a new packet. The new packet keeps the header and destination address of the packet before it. Flow control uses two wait outputs, one for read traffic and one for all other traffic. Each one rises two edges after a packet of its class is buffered. At that point one more complete packet still fits, so a packet already in flight when the wait appears is not lost.

Top module: `meshFrameRx`

## Requirements
- R1: While reset is applied, and until the first packet is buffered after it, outValid, waitRd and waitWr are low.
- R2: A byte counts as the first byte of a packet only when the frame bit is high on its edge and was low on the edge before. Bytes on edges with the frame bit low never produce a packet.
- R3: The first byte is {ctrlMode[7:4], dataMode[3:2], write[1], access[0]}. Bytes 1–4 carry the destination address, bytes 5–8 the data word and bytes 9–12 the source address, each most significant byte first.
- R4: A packet is 13 bytes long when write is 0, or when write is 1 and dataMode is 11. Every other packet is 9 bytes long. A 9-byte packet is delivered with outSrcAddr equal to zero.
- R5: If the frame bit is still high on the edge after a packet's last byte, that byte is byte 5 of a new packet. The new packet reuses bytes 0–4 of the previous packet, including its length.
- R6: If the frame bit is low on the edge after the last byte, the packet is complete. If the frame bit goes low before the last byte, the partial packet is dropped, and nothing is received again until a new low-to-high frame edge.
- R7: A completed packet is shown on the outputs in the cycle after its last byte. Packets leave in arrival order, one on each cycle where outValid and outReady are both high. The head packet does not change while it waits. Up to two packets are held.
- R8: After each clock edge k, waitRd is high exactly when the buffer held a read packet (access 1, write 0) after edge k-2. waitWr follows the same rule for any packet that is not a read.
- R9: A packet that begins before a wait output becomes visible is still stored and delivered. This holds whether the packet starts from a fresh frame edge or is streamed directly behind the packet that raised the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link capture clock, one byte per rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| linkFrame | input | 1 | Frame bit sampled with each byte |
| linkByte | input | 8 | Link data byte |
| outReady | input | 1 | Downstream accepts the head packet |
| outValid | output | 1 | A packet is present on the field outputs |
| outAccess | output | 1 | Access bit of the head packet |
| outWrite | output | 1 | Write bit of the head packet |
| outDataMode | output | 2 | Data size code (00 8-bit, 01 16-bit, 10 32-bit, 11 64-bit) |
| outCtrlMode | output | 4 | Control mode nibble |
| outDstAddr | output | 32 | Destination address |
| outData | output | 32 | Data word |
| outSrcAddr | output | 32 | Source address or upper data; zero for 9-byte packets |
| waitRd | output | 1 | Back-pressure for read packets |
| waitWr | output | 1 | Back-pressure for all other packets |

## Verification
The assertions rely on three things about the inputs. The frame bit stays low while reset is applied. The sender never starts a packet, fresh or streamed, while either wait output is high. And because of that, a third packet never reaches a full buffer that is not being drained. The stimulus meets these conditions in two ways. It keeps the frame bit low through reset. It also reads both waits at the negative edge before driving a first byte or a streamed byte 5, and it ends the frame instead of streaming when either wait is set. Within these rules, the bench varies back-pressure among always ready, never ready and random. It also drops the frame partway through fresh and streamed packets.

// File: rtl/meshRxPkg.sv
package meshRxPkg;

  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 32;
  localparam int DATA_W      = 32;
  localparam int CTRL_W      = 4;
  localparam int MODE_W      = 2;
  localparam int ADDR_BYTES  = ADDR_W / BYTE_W;
  localparam int DATA_BYTES  = DATA_W / BYTE_W;
  localparam int HDR_BYTES   = 1 + ADDR_BYTES;
  localparam int SHORT_BYTES = HDR_BYTES + DATA_BYTES;
  localparam int LONG_BYTES  = SHORT_BYTES + ADDR_BYTES;
  localparam int IDX_W       = $clog2(LONG_BYTES);

  typedef struct packed {
    logic              access;
    logic              write;
    logic [MODE_W-1:0] dataMode;
    logic [CTRL_W-1:0] ctrlMode;
    logic [ADDR_W-1:0] dstAddr;
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] srcAddr;
  } meshPkt_t;

  // strobes from the sequencer to the byte datapath
  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] byteIdx;
    logic             commit;
    logic             isLong;
  } rxStrobe_t;

  // reads and 64-bit writes carry a trailing address word
  function automatic logic needsLong(input logic isWrite, input logic [MODE_W-1:0] mode);
    return !isWrite || (mode == 2'b11);
  endfunction

endpackage

// File: rtl/meshRxCtrl.sv
module meshRxCtrl
  import meshRxPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             linkFrame,
  input  logic [2:0]       hdrBits,   // {dataMode, write} of the current byte
  output rxStrobe_t        stb
);

  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_BYTES - 1);
  localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_BYTES - 1);
  localparam logic [IDX_W-1:0] STREAM_IDX = IDX_W'(HDR_BYTES);

  logic             prevFrame;
  logic             inPkt;
  logic             longQ;
  logic [IDX_W-1:0] idxQ;

  logic             startEdge;
  logic             hdrLong;
  logic [IDX_W-1:0] lastIdx;

  assign startEdge = linkFrame && !prevFrame;
  assign hdrLong   = needsLong(hdrBits[0], hdrBits[2:1]);
  assign lastIdx   = longQ ? LONG_LAST : SHORT_LAST;

  always_comb begin
    stb.capture = startEdge || (inPkt && linkFrame);
    stb.byteIdx = startEdge ? '0 : idxQ;
    stb.isLong  = startEdge ? hdrLong : longQ;
    stb.commit  = !startEdge && inPkt && linkFrame && (idxQ == lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFrame <= 1'b0;
      inPkt     <= 1'b0;
      longQ     <= 1'b0;
      idxQ      <= '0;
    end else begin
      prevFrame <= linkFrame;
      if (startEdge) begin
        inPkt <= 1'b1;
        longQ <= hdrLong;
        idxQ  <= IDX_W'(1);
      end else if (inPkt) begin
        if (!linkFrame) begin
          // frame dropped: either a clean end or an abandoned packet
          inPkt <= 1'b0;
        end else if (stb.commit) begin
          // keep going: a held frame continues at the data bytes
          idxQ <= STREAM_IDX;
        end else begin
          idxQ <= idxQ + IDX_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/meshRxDatapath.sv
module meshRxDatapath
  import meshRxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic [BYTE_W-1:0] linkByte,
  output meshPkt_t          pktOut,
  output logic              pushStb
);

  logic [BYTE_W-1:0] cur [LONG_BYTES];

  for (genvar g = 0; g < LONG_BYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] held;
    logic              hit;
    assign hit = stb.capture && (stb.byteIdx == IDX_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    held <= '0;
      else if (hit) held <= linkByte;
    end
    // the final byte is used straight from the link
    assign cur[g] = hit ? linkByte : held;
  end

  always_comb begin
    pktOut.access   = cur[0][0];
    pktOut.write    = cur[0][1];
    pktOut.dataMode = cur[0][3:2];
    pktOut.ctrlMode = cur[0][7:4];
    pktOut.dstAddr  = '0;
    pktOut.data     = '0;
    pktOut.srcAddr  = '0;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      pktOut.dstAddr[ADDR_W-1-k*BYTE_W -: BYTE_W] = cur[1 + k];
    end
    for (int k = 0; k < DATA_BYTES; k++) begin
      pktOut.data[DATA_W-1-k*BYTE_W -: BYTE_W] = cur[HDR_BYTES + k];
    end
    if (stb.isLong) begin
      for (int k = 0; k < ADDR_BYTES; k++) begin
        pktOut.srcAddr[ADDR_W-1-k*BYTE_W -: BYTE_W] = cur[SHORT_BYTES + k];
      end
    end
  end

  assign pushStb = stb.commit;

endmodule

// File: rtl/meshRxBuf.sv
module meshRxBuf
  import meshRxPkg::*;
#(
  parameter int DEPTH    = 2,
  parameter int WAIT_LAG = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     push,
  input  meshPkt_t pktIn,
  input  logic     popReady,
  output meshPkt_t headPkt,
  output logic     headValid,
  output logic     waitRd,
  output logic     waitWr
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] PRESSURE = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  meshPkt_t         mem [DEPTH];
  logic [DEPTH-1:0] slotFull;
  logic [DEPTH-1:0] slotRd;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  logic pop, pushOk, full, rdNow, wrNow;

  assign full      = (count == FULL_CNT);
  assign headValid = (count != '0);
  assign headPkt   = mem[rdPtr];
  assign pop       = headValid && popReady;
  assign pushOk    = push && (!full || pop);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      slotFull <= '0;
      slotRd   <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
    end else begin
      if (pop) begin
        slotFull[rdPtr] <= 1'b0;
        rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + PTR_W'(1);
      end
      if (pushOk) begin
        mem[wrPtr]      <= pktIn;
        slotFull[wrPtr] <= 1'b1;
        slotRd[wrPtr]   <= pktIn.access && !pktIn.write;
        wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + PTR_W'(1);
      end
      count <= count + CNT_W'(pushOk) - CNT_W'(pop);
    end
  end

  // raise a class wait while fewer than two slots are free and that class is held
  assign rdNow = (count >= PRESSURE) && |(slotFull & slotRd);
  assign wrNow = (count >= PRESSURE) && |(slotFull & ~slotRd);

  logic [WAIT_LAG-1:0] rdPipe, wrPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPipe <= '0;
      wrPipe <= '0;
    end else begin
      rdPipe <= {rdPipe[WAIT_LAG-2:0], rdNow};
      wrPipe <= {wrPipe[WAIT_LAG-2:0], wrNow};
    end
  end

  assign waitRd = rdPipe[WAIT_LAG-1];
  assign waitWr = wrPipe[WAIT_LAG-1];

endmodule

// File: rtl/meshFrameRx.sv
module meshFrameRx
  import meshRxPkg::*;
#(
  parameter int DEPTH    = 2,
  parameter int WAIT_LAG = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkFrame,
  input  logic [BYTE_W-1:0] linkByte,
  input  logic              outReady,
  output logic              outValid,
  output logic              outAccess,
  output logic              outWrite,
  output logic [MODE_W-1:0] outDataMode,
  output logic [CTRL_W-1:0] outCtrlMode,
  output logic [ADDR_W-1:0] outDstAddr,
  output logic [DATA_W-1:0] outData,
  output logic [ADDR_W-1:0] outSrcAddr,
  output logic              waitRd,
  output logic              waitWr
);

  rxStrobe_t stb;
  meshPkt_t  asmPkt;
  meshPkt_t  headPkt;
  logic      pushStb;

  meshRxCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .linkFrame (linkFrame),
    .hdrBits   (linkByte[3:1]),
    .stb       (stb)
  );

  meshRxDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .linkByte (linkByte),
    .pktOut   (asmPkt),
    .pushStb  (pushStb)
  );

  meshRxBuf #(.DEPTH(DEPTH), .WAIT_LAG(WAIT_LAG)) u_buf (
    .clk       (clk),
    .rstN      (rstN),
    .push      (pushStb),
    .pktIn     (asmPkt),
    .popReady  (outReady),
    .headPkt   (headPkt),
    .headValid (outValid),
    .waitRd    (waitRd),
    .waitWr    (waitWr)
  );

  assign outAccess   = headPkt.access;
  assign outWrite    = headPkt.write;
  assign outDataMode = headPkt.dataMode;
  assign outCtrlMode = headPkt.ctrlMode;
  assign outDstAddr  = headPkt.dstAddr;
  assign outData     = headPkt.data;
  assign outSrcAddr  = headPkt.srcAddr;

endmodule

// File: rtl/meshRxChk.sv
module meshRxChk
  import meshRxPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              linkFrame,
  input logic              outReady,
  input logic              outValid,
  input logic              waitRd,
  input logic              waitWr,
  input logic [ADDR_W-1:0] outDstAddr,
  input logic [DATA_W-1:0] outData,
  input logic [ADDR_W-1:0] outSrcAddr,
  input logic              pushStb,
  input logic              captureStb,
  input logic [IDX_W-1:0]  captureIdx
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && !waitRd && !waitWr));

  // R2
  byte0_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (captureStb && captureIdx == '0) |-> (linkFrame && !$past(linkFrame)));

  // R6
  commit_framed_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushStb |-> (linkFrame && captureStb));

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=>
      (outValid && $stable(outDstAddr) && $stable(outData) && $stable(outSrcAddr)));

  // R8
  wait_rd_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitRd) |-> $past(outValid, 2));

  // R8
  wait_wr_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitWr) |-> $past(outValid, 2));

endmodule

bind meshFrameRx meshRxChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .linkFrame  (linkFrame),
  .outReady   (outReady),
  .outValid   (outValid),
  .waitRd     (waitRd),
  .waitWr     (waitWr),
  .outDstAddr (outDstAddr),
  .outData    (outData),
  .outSrcAddr (outSrcAddr),
  .pushStb    (pushStb),
  .captureStb (stb.capture),
  .captureIdx (stb.byteIdx)
);

// File: tb/sim_meshFrameRx.sv
`timescale 1ns/1ps
module sim_meshFrameRx;

  logic        clk = 1'b0;
  logic        rstN;
  logic        linkFrame;
  logic [7:0]  linkByte;
  logic        outReady;
  logic        outValid, outAccess, outWrite, waitRd, waitWr;
  logic [1:0]  outDataMode;
  logic [3:0]  outCtrlMode;
  logic [31:0] outDstAddr, outData, outSrcAddr;

  always #2 clk = ~clk;

  meshFrameRx u0 (
    .clk(clk), .rstN(rstN), .linkFrame(linkFrame), .linkByte(linkByte),
    .outReady(outReady), .outValid(outValid), .outAccess(outAccess),
    .outWrite(outWrite), .outDataMode(outDataMode), .outCtrlMode(outCtrlMode),
    .outDstAddr(outDstAddr), .outData(outData), .outSrcAddr(outSrcAddr),
    .waitRd(waitRd), .waitWr(waitWr)
  );

  int nChecks = 0;
  int nErr    = 0;
  bit running = 1'b0;
  int readyMode = 1;   // 0 stall, 1 always, 2 random

  // ---------------- reference model ----------------
  logic [103:0] expQ [$];
  bit           pushNow = 1'b0;
  logic [103:0] pushPkt = '0;
  bit           s1Rd, s1Wr, expWaitRd, expWaitWr;
  int           popCnt = 0;

  function automatic bit isRead(logic [103:0] p);
    return p[103] && !p[102];
  endfunction

  function automatic bit isLong(logic [103:0] p);
    return !p[102] || (p[101:100] == 2'b11);
  endfunction

  function automatic int lastIdx(logic [103:0] p);
    return isLong(p) ? 12 : 8;
  endfunction

  function automatic logic [7:0] byteOf(logic [103:0] p, int i);
    if (i == 0) return {p[99:96], p[101:100], p[102], p[103]};
    return 8'(p >> (96 - 8 * i));
  endfunction

  function automatic logic [103:0] mkPkt(bit acc, bit wr, logic [1:0] dm, logic [3:0] cm,
                                         logic [31:0] dst, logic [31:0] dat, logic [31:0] src);
    logic [103:0] p;
    p = {acc, wr, dm, cm, dst, dat, src};
    if (!isLong(p)) p[31:0] = '0;
    return p;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expQ.delete();
      s1Rd = 0; s1Wr = 0; expWaitRd = 0; expWaitWr = 0;
    end else begin
      bit hr, hw;
      hr = 0; hw = 0;
      foreach (expQ[i]) begin
        if (isRead(expQ[i])) hr = 1; else hw = 1;
      end
      expWaitRd = s1Rd; expWaitWr = s1Wr;
      s1Rd = hr; s1Wr = hw;
      if (expQ.size() > 0 && outReady) begin
        void'(expQ.pop_front());
        popCnt++;
      end
      if (pushNow) expQ.push_back(pushPkt);
    end
  end

  // ---------------- checking ----------------
  task automatic check(bit ok, string tag, logic [103:0] act, logic [103:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && rstN) begin
      logic [103:0] act;
      act = {outAccess, outWrite, outDataMode, outCtrlMode, outDstAddr, outData, outSrcAddr};
      check(outValid == (expQ.size() > 0), "R7 outValid", 104'(outValid), 104'(expQ.size() > 0));
      if (outValid && expQ.size() > 0)
        check(act == expQ[0], "R3 R4 head fields", act, expQ[0]);
      check(waitRd == expWaitRd, "R8 waitRd", 104'(waitRd), 104'(expWaitRd));
      check(waitWr == expWaitWr, "R8 waitWr", 104'(waitWr), 104'(expWaitWr));
    end
  end

  always @(negedge clk) begin
    case (readyMode)
      0:       outReady = 1'b0;
      1:       outReady = 1'b1;
      default: outReady = ($urandom % 10) < 6;
    endcase
  end

  // ---------------- driver ----------------
  task automatic drv(bit f, logic [7:0] b, bit last, logic [103:0] p);
    @(negedge clk);
    linkFrame = f; linkByte = b; pushNow = last; pushPkt = p;
  endtask

  // fresh packet; abortAt = byte index where frame drops (0 = none)
  task automatic startPkt(logic [103:0] p, int abortAt, output bit done);
    drv(0, 8'h5A, 0, '0);
    forever begin
      @(negedge clk);
      pushNow = 0;
      if (!waitRd && !waitWr) break;
      linkFrame = 0; linkByte = 8'hC3;
    end
    linkFrame = 1; linkByte = byteOf(p, 0);
    done = 1;
    for (int i = 1; i <= lastIdx(p); i++) begin
      if (i == abortAt) begin drv(0, 8'hEE, 0, '0); done = 0; return; end
      drv(1, byteOf(p, i), i == lastIdx(p), p);
    end
  endtask

  // streamed packet right after a completed one; ok=0 if it could not stream or aborted
  task automatic streamPkt(logic [103:0] p, int abortAt, output bit ok);
    @(negedge clk);
    pushNow = 0;
    if (waitRd || waitWr || abortAt == 5) begin
      linkFrame = 0; linkByte = 8'h00; ok = 0; return;
    end
    linkFrame = 1; linkByte = byteOf(p, 5);
    ok = 1;
    for (int i = 6; i <= lastIdx(p); i++) begin
      if (i == abortAt) begin drv(0, 8'hEE, 0, '0); ok = 0; return; end
      drv(1, byteOf(p, i), i == lastIdx(p), p);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drv(0, 8'(i * 37), 0, '0);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finishRun();
  end

  initial begin
    bit done, ok;
    int base;
    logic [103:0] p, q;
    rstN = 0; linkFrame = 0; linkByte = 0; outReady = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!outValid && !waitRd && !waitWr, "R1 reset outputs",
          {outValid, waitRd, waitWr}, '0);
    rstN = 1;
    running = 1;
    idle(3);
    check(!outValid && !waitRd && !waitWr, "R1 after release", {outValid, waitRd, waitWr}, '0);

    // R2: bytes with frame low do nothing
    idle(8);
    check(popCnt == 0 && !outValid, "R2 frame-low bytes ignored", 104'(popCnt), 0);

    // R3 R4: assorted lengths and modes
    startPkt(mkPkt(1, 1, 2'b10, 4'h3, 32'h1122_3344, 32'hA1B2_C3D4, 32'h0), 0, done);
    startPkt(mkPkt(1, 1, 2'b11, 4'h9, 32'h8000_0010, 32'h0BAD_F00D, 32'hCAFE_0001), 0, done);
    startPkt(mkPkt(1, 0, 2'b10, 4'hF, 32'h0000_00FC, 32'h0, 32'h7654_3210), 0, done);
    startPkt(mkPkt(1, 1, 2'b00, 4'h0, 32'hFFFF_FFFF, 32'h0000_00AB, 32'h0), 0, done);
    startPkt(mkPkt(0, 1, 2'b01, 4'h6, 32'h0123_4567, 32'h0000_BEEF, 32'h0), 0, done);
    idle(6);
    check(popCnt == 5, "R4 all lengths delivered", 104'(popCnt), 5);

    // R5: streaming, short and long
    base = popCnt;
    p = mkPkt(1, 1, 2'b10, 4'h2, 32'h0000_4000, 32'h1, 32'h0);
    startPkt(p, 0, done);
    for (int s = 0; s < 3; s++) begin
      q = p; q[63:32] = 32'h1000 + s;
      streamPkt(q, 0, ok);
      check(ok, "R5 stream accepted", 104'(ok), 1);
    end
    p = mkPkt(1, 1, 2'b11, 4'h4, 32'h0000_5000, 32'h2, 32'h3);
    startPkt(p, 0, done);
    q = p; q[63:0] = 64'hDEAD_BEEF_0BAD_CAFE;
    streamPkt(q, 0, ok);
    idle(6);
    check(popCnt - base == 6, "R5 streamed packets delivered", 104'(popCnt - base), 6);

    // R6: drop frame mid-packet, fresh and streamed
    base = popCnt;
    startPkt(mkPkt(1, 1, 2'b10, 4'h1, 32'h1, 32'h2, 32'h0), 3, done);
    idle(4);
    check(popCnt == base && !outValid, "R6 partial discarded", 104'(popCnt - base), 0);
    startPkt(mkPkt(1, 1, 2'b10, 4'h1, 32'h9, 32'h8, 32'h0), 0, done);
    q = mkPkt(1, 1, 2'b10, 4'h1, 32'h9, 32'h77, 32'h0);
    streamPkt(q, 7, ok);
    idle(6);
    check(popCnt - base == 1, "R6 streamed partial discarded", 104'(popCnt - base), 1);

    // R9 R8: stall the output, stream one more behind a read
    base = popCnt;
    readyMode = 0;
    idle(2);
    p = mkPkt(1, 0, 2'b10, 4'h5, 32'h0000_0A00, 32'h0, 32'h0000_0B00);
    startPkt(p, 0, done);
    q = p; q[63:0] = 64'h0000_0001_0000_0C00;
    streamPkt(q, 0, ok);
    drv(0, 8'h00, 0, '0);
    idle(4);
    check(outValid && waitRd && !waitWr, "R8 read wait while stalled",
          {outValid, waitRd, waitWr}, 3'b110);
    check(expQ.size() == 2, "R9 second packet held", 104'(expQ.size()), 2);
    fork
      begin repeat (12) @(negedge clk); readyMode = 1; end
    join_none
    startPkt(mkPkt(1, 1, 2'b10, 4'h7, 32'h3, 32'h4, 32'h0), 0, done);
    idle(8);
    check(popCnt - base == 3, "R9 no packet lost", 104'(popCnt - base), 3);

    // mixed random traffic
    readyMode = 2;
    for (int n = 0; n < 150; n++) begin
      bit wr, acc;
      int ab;
      acc = ($urandom % 5) != 0;
      wr  = $urandom % 2;
      p = mkPkt(acc, wr, 2'($urandom), 4'($urandom), $urandom, $urandom, $urandom);
      ab = (($urandom % 10) == 0) ? 1 + ($urandom % lastIdx(p)) : 0;
      startPkt(p, ab, done);
      while (done && ($urandom % 3) == 0) begin
        q = p; q[63:0] = {$urandom, $urandom};
        if (!isLong(q)) q[31:0] = '0;
        ab = (($urandom % 8) == 0) ? 5 + ($urandom % (lastIdx(q) - 4)) : 0;
        streamPkt(q, ab, done);
        p = q;
      end
    end

    readyMode = 1;
    idle(20);
    check(!outValid && expQ.size() == 0, "R7 drained at end", 104'(outValid), 0);
    check(!waitRd && !waitWr, "R8 waits released", {waitRd, waitWr}, 0);
    finishRun();
  end

endmodule